// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block decides, every cycle, how the front pipeline registers of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) update. It looks at the operation codes and register numbers held in those registers and at the branch condition computed in execute. For the fetch, decode and execute registers it raises stall and bubble requests. A stall keeps a register's contents. A bubble replaces them with an idle encoding.

Three situations are handled:
- A loaded value is needed by the instruction right behind the load.
- A conditional jump that was predicted taken turns out not taken.
- A return is still on its way down the pipe.

When a load/use conflict and a pending return arrive together, the load/use conflict wins. The decode register only stalls, so it is never asked to stall and bubble at the same time.

The top level wraps the control logic around the pipeline registers themselves. The fetch register is a program counter that steps by one when it updates. Each later register carries an operation code and three register numbers. This lets the effect of each control decision be observed on the register outputs.

Top module: `hazard_pipe`

## Requirements
- R1: During and right after reset, the decode, execute, memory and write-back registers hold the idle encoding: operation code 1 and register numbers 15. The program counter is 0, and `conflict_err` is low.
- R2: A load/use conflict exists when the execute-stage operation is a load (code 5) or a pop (code 11) and its destination register equals the first or the second source of the decode-stage instruction. In that cycle `f_stall`, `d_stall` and `e_bubble` are high and `d_bubble` is low.
- R3: A load/use conflict costs exactly one cycle. After the edge, execute holds the idle code, decode still holds the consumer, and the program counter is unchanged. One edge later the consumer is in execute.
- R4: Register number 15 means no register and never produces a load/use match.
- R5: When execute holds a conditional jump (code 7) and `exe_cond` is 0, `d_bubble` and `e_bubble` are high and `f_stall` is low (with no return in flight). After the edge, decode and execute hold the idle encoding and the program counter has advanced by one.
- R6: When execute holds a conditional jump and `exe_cond` is 1, no stall or bubble is raised, and the instructions behind the jump advance normally.
- R7: While a return (code 9) sits in decode, execute or memory, `f_stall` and `d_bubble` are high. The stall ends once the return reaches write-back, which makes exactly three stalled cycles with the program counter held.
- R8: When a load/use conflict coincides with a return in decode, decode stalls and is not bubbled. The return stays in decode for one extra cycle and then proceeds.
- R9: When a not-taken jump is in execute and a return is in decode, both are cancelled as a misprediction: decode and execute are bubbled, and the return never reaches execute.
- R10: A register in stall mode keeps its value across the edge. A register in bubble mode loads the idle encoding. The memory and write-back registers always take the value of the register before them.
- R11: If any register were asked to stall and bubble at once, the bubble wins and `conflict_err` sets and stays set. Under this control logic the flag stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_op | input | 4 | Operation code of the instruction being fetched |
| in_srca | input | 4 | First source register of the fetched instruction |
| in_srcb | input | 4 | Second source register of the fetched instruction |
| in_dstm | input | 4 | Memory destination register of the fetched instruction |
| exe_cond | input | 1 | Branch condition computed for the execute-stage instruction |
| f_stall | output | 1 | Fetch register stall request |
| d_stall | output | 1 | Decode register stall request |
| d_bubble | output | 1 | Decode register bubble request |
| e_bubble | output | 1 | Execute register bubble request |
| pc_q | output | PC_W | Fetch register (program counter) |
| d_op | output | 4 | Decode-stage operation code |
| d_dst | output | 4 | Decode-stage destination register |
| e_op | output | 4 | Execute-stage operation code |
| e_dst | output | 4 | Execute-stage destination register |
| m_op | output | 4 | Memory-stage operation code |
| m_dst | output | 4 | Memory-stage destination register |
| w_op | output | 4 | Write-back-stage operation code |
| w_dst | output | 4 | Write-back-stage destination register |
| conflict_err | output | 1 | Sticky flag: a register got stall and bubble together |

## Verification
The four control requests are combinational functions of the registered stage contents and `exe_cond`, so they are due in the same cycle as the stimulus. The bench changes the inputs 1 ns after a rising edge and samples the requests 1 ns later, well before the next edge. The effect of a request on the pipeline registers and the program counter appears one rising edge later. Those values are sampled 1 ns after that edge. For returns, the bench walks the pipe one edge at a time and counts the stalled cycles until the return has reached write-back.

// File: rtl/hzc_pkg.sv
`timescale 1ns/1ps
package hzc_pkg;
  localparam int OP_W  = 4;
  localparam int RID_W = 4;

  localparam logic [RID_W-1:0] NO_REG = '1;

  localparam logic [OP_W-1:0] OP_NOP  = OP_W'(1);
  localparam logic [OP_W-1:0] OP_LOAD = OP_W'(5);
  localparam logic [OP_W-1:0] OP_ALU  = OP_W'(6);
  localparam logic [OP_W-1:0] OP_JCC  = OP_W'(7);
  localparam logic [OP_W-1:0] OP_RET  = OP_W'(9);
  localparam logic [OP_W-1:0] OP_POP  = OP_W'(11);

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [RID_W-1:0] srca;
    logic [RID_W-1:0] srcb;
    logic [RID_W-1:0] dstm;
  } slot_t;

  localparam int SLOT_W = $bits(slot_t);
  localparam slot_t SLOT_IDLE = '{op: OP_NOP, srca: NO_REG, srcb: NO_REG, dstm: NO_REG};

  // operation fills a register from memory
  function automatic logic fills_from_mem(input logic [OP_W-1:0] op);
    return (op == OP_LOAD) || (op == OP_POP);
  endfunction

  // a real destination register equal to a source
  function automatic logic reg_hit(input logic [RID_W-1:0] dst, input logic [RID_W-1:0] src);
    return (dst != NO_REG) && (dst == src);
  endfunction
endpackage

// File: rtl/hzc_stage_reg.sv
`timescale 1ns/1ps
module hzc_stage_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] IDLE_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stall,
  input  logic         bubble,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         clash
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= IDLE_VAL;
    else if (bubble)  q <= IDLE_VAL;
    else if (!stall)  q <= d;
  end

  assign clash = stall & bubble;

  // R10
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !bubble) |=> $stable(q));
  // R10
  idle_on_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> (q == IDLE_VAL));
endmodule

// File: rtl/hzc_detect.sv
`timescale 1ns/1ps
module hzc_detect
  import hzc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  d_op,
  input  logic [RID_W-1:0] d_srca,
  input  logic [RID_W-1:0] d_srcb,
  input  logic [OP_W-1:0]  e_op,
  input  logic [RID_W-1:0] e_dstm,
  input  logic [OP_W-1:0]  m_op,
  input  logic             exe_cond,
  output logic             lu_hit,
  output logic             mis_hit,
  output logic             ret_busy,
  output logic             f_stall,
  output logic             d_stall,
  output logic             d_bubble,
  output logic             e_bubble
);
  always_comb begin
    lu_hit   = fills_from_mem(e_op) && (reg_hit(e_dstm, d_srca) || reg_hit(e_dstm, d_srcb));
    mis_hit  = (e_op == OP_JCC) && !exe_cond;
    ret_busy = (d_op == OP_RET) || (e_op == OP_RET) || (m_op == OP_RET);
  end

  always_comb begin
    f_stall  = lu_hit || ret_busy;
    d_stall  = lu_hit;
    // load/use takes priority over the pending return
    d_bubble = mis_hit || (ret_busy && !lu_hit);
    e_bubble = mis_hit || lu_hit;
  end

  // R8
  d_mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(d_stall && d_bubble));
  // R4
  noreg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fills_from_mem(e_op) && e_dstm == NO_REG) |-> !d_stall);
  // R6
  taken_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (e_op == OP_JCC && exe_cond && !ret_busy) |-> !(d_bubble || e_bubble || f_stall));
  // R7
  ret_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_busy && !mis_hit && !lu_hit) |-> (f_stall && d_bubble));
endmodule

// File: rtl/hazard_pipe.sv
`timescale 1ns/1ps
module hazard_pipe
  import hzc_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  in_op,
  input  logic [RID_W-1:0] in_srca,
  input  logic [RID_W-1:0] in_srcb,
  input  logic [RID_W-1:0] in_dstm,
  input  logic             exe_cond,
  output logic             f_stall,
  output logic             d_stall,
  output logic             d_bubble,
  output logic             e_bubble,
  output logic [PC_W-1:0]  pc_q,
  output logic [OP_W-1:0]  d_op,
  output logic [RID_W-1:0] d_dst,
  output logic [OP_W-1:0]  e_op,
  output logic [RID_W-1:0] e_dst,
  output logic [OP_W-1:0]  m_op,
  output logic [RID_W-1:0] m_dst,
  output logic [OP_W-1:0]  w_op,
  output logic [RID_W-1:0] w_dst,
  output logic             conflict_err
);
  localparam int NSTG = 4;              // decode, execute, memory, write-back
  localparam int SD = 0, SE = 1, SM = 2, SW = 3;
  localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

  slot_t           in_slot;
  slot_t           stg_d [NSTG];
  slot_t           stg_q [NSTG];
  logic [NSTG-1:0] stg_stall, stg_bub, stg_clash;
  logic            f_clash;
  logic [PC_W-1:0] pc_next;
  logic            lu_hit, mis_hit, ret_busy;

  assign in_slot = '{op: in_op, srca: in_srca, srcb: in_srcb, dstm: in_dstm};

  hzc_detect u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .d_op     (stg_q[SD].op),
    .d_srca   (stg_q[SD].srca),
    .d_srcb   (stg_q[SD].srcb),
    .e_op     (stg_q[SE].op),
    .e_dstm   (stg_q[SE].dstm),
    .m_op     (stg_q[SM].op),
    .exe_cond (exe_cond),
    .lu_hit   (lu_hit),
    .mis_hit  (mis_hit),
    .ret_busy (ret_busy),
    .f_stall  (f_stall),
    .d_stall  (d_stall),
    .d_bubble (d_bubble),
    .e_bubble (e_bubble)
  );

  // fetch register: program counter
  assign pc_next = pc_q + PC_ONE;

  hzc_stage_reg #(.W(PC_W), .IDLE_VAL('0)) u_freg (
    .clk    (clk),
    .rst_n  (rst_n),
    .stall  (f_stall),
    .bubble (1'b0),
    .d      (pc_next),
    .q      (pc_q),
    .clash  (f_clash)
  );

  assign stg_stall = {1'b0, 1'b0, 1'b0, d_stall};
  assign stg_bub   = {1'b0, 1'b0, e_bubble, d_bubble};

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign stg_d[g] = in_slot;
    end else begin : g_chain
      assign stg_d[g] = stg_q[g-1];
    end
    hzc_stage_reg #(.W(SLOT_W), .IDLE_VAL(SLOT_IDLE)) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .stall  (stg_stall[g]),
      .bubble (stg_bub[g]),
      .d      (stg_d[g]),
      .q      (stg_q[g]),
      .clash  (stg_clash[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conflict_err <= 1'b0;
    else if (f_clash || (|stg_clash)) conflict_err <= 1'b1;
  end

  assign d_op  = stg_q[SD].op;
  assign d_dst = stg_q[SD].dstm;
  assign e_op  = stg_q[SE].op;
  assign e_dst = stg_q[SE].dstm;
  assign m_op  = stg_q[SM].op;
  assign m_dst = stg_q[SM].dstm;
  assign w_op  = stg_q[SW].op;
  assign w_dst = stg_q[SW].dstm;

  // R3
  lu_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lu_hit |=> (stg_q[SE].op == OP_NOP) && $stable(stg_q[SD]) && $stable(pc_q));
  // R5
  mis_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mis_hit |=> (stg_q[SD].op == OP_NOP) && (stg_q[SE].op == OP_NOP));
  // R7
  ret_pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_busy |=> $stable(pc_q));
  // R9
  ret_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mis_hit && stg_q[SD].op == OP_RET) |=> (stg_q[SE].op != OP_RET));
  // R10
  mem_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stg_q[SM] == $past(stg_q[SE])) && (stg_q[SW] == $past(stg_q[SM])));
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict_err || f_clash || (|stg_clash)) |=> conflict_err);
endmodule

// File: tb/hazard_pipe_bench.sv
`timescale 1ns/1ps
module hazard_pipe_bench;
  localparam int NOP = 1, LOAD = 5, ALU = 6, JCC = 7, RET = 9, POP = 11, NR = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] in_op = 4'(NOP), in_srca = 4'(NR), in_srcb = 4'(NR), in_dstm = 4'(NR);
  logic       exe_cond = 1'b1;
  logic       f_stall, d_stall, d_bubble, e_bubble, conflict_err;
  logic [7:0] pc_q;
  logic [3:0] d_op, d_dst, e_op, e_dst, m_op, m_dst, w_op, w_dst;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  hazard_pipe u_hazard_pipe (
    .clk(clk), .rst_n(rst_n), .in_op(in_op), .in_srca(in_srca), .in_srcb(in_srcb),
    .in_dstm(in_dstm), .exe_cond(exe_cond), .f_stall(f_stall), .d_stall(d_stall),
    .d_bubble(d_bubble), .e_bubble(e_bubble), .pc_q(pc_q), .d_op(d_op), .d_dst(d_dst),
    .e_op(e_op), .e_dst(e_dst), .m_op(m_op), .m_dst(m_dst), .w_op(w_op), .w_dst(w_dst),
    .conflict_err(conflict_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic settle;
    #1;
  endtask

  task automatic present(input int op, input int sa, input int sb, input int dst);
    in_op = 4'(op); in_srca = 4'(sa); in_srcb = 4'(sb); in_dstm = 4'(dst);
  endtask

  task automatic flush;
    exe_cond = 1'b1;
    present(NOP, NR, NR, NR);
    repeat (6) tick();
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 d_op", int'(d_op), NOP);  chk("R1 d_dst", int'(d_dst), NR);
    chk("R1 e_op", int'(e_op), NOP);  chk("R1 m_op", int'(m_op), NOP);
    chk("R1 w_op", int'(w_op), NOP);  chk("R1 pc", int'(pc_q), 0);
    chk("R1 err", int'(conflict_err), 0);
    rst_n = 1'b1;
    settle();
    chk("R1 f_stall", int'(f_stall), 0);
    chk("R1 d_bubble", int'(d_bubble), 0);
  endtask

  task automatic t_load_use(input int op, input int dst, input bit use_a);
    int pc0;
    present(op, NR, NR, dst); tick();
    if (use_a) present(ALU, dst, NR, 6); else present(ALU, NR, dst, 6);
    tick(); settle();
    chk("R2 f_stall", int'(f_stall), 1);
    chk("R2 d_stall", int'(d_stall), 1);
    chk("R2 e_bubble", int'(e_bubble), 1);
    chk("R2 d_bubble", int'(d_bubble), 0);
    pc0 = int'(pc_q);
    tick();
    chk("R3 e_op idle", int'(e_op), NOP);
    chk("R3 d_dst held", int'(d_dst), 6);
    chk("R3 pc held", int'(pc_q), pc0);
    chk("R10 m_op follows", int'(m_op), op);
    chk("R3 f_stall cleared", int'(f_stall), 0);
    present(NOP, NR, NR, NR); tick();
    chk("R3 consumer in E", int'(e_op), ALU);
    chk("R3 consumer tag", int'(e_dst), 6);
    flush();
  endtask

  task automatic t_noreg;
    present(LOAD, NR, NR, NR); tick();
    present(ALU, NR, NR, 6); tick(); settle();
    chk("R4 d_stall", int'(d_stall), 0);
    chk("R4 f_stall", int'(f_stall), 0);
    flush();
    present(LOAD, NR, NR, 3); tick();
    present(ALU, NR, NR, 6); tick(); settle();
    chk("R4 absent sources", int'(d_stall), 0);
    flush();
  endtask

  task automatic t_jump(input bit cond);
    int pc0;
    present(JCC, NR, NR, NR); tick();
    present(ALU, NR, NR, 4); tick();
    exe_cond = cond;
    present(ALU, NR, NR, 5); settle();
    pc0 = int'(pc_q);
    if (!cond) begin
      chk("R5 d_bubble", int'(d_bubble), 1);
      chk("R5 e_bubble", int'(e_bubble), 1);
      chk("R5 f_stall", int'(f_stall), 0);
      tick();
      chk("R5 d idle", int'(d_op), NOP);
      chk("R10 d idle regs", int'(d_dst), NR);
      chk("R5 e idle", int'(e_op), NOP);
      chk("R5 m jump", int'(m_op), JCC);
      chk("R5 pc step", int'(pc_q), (pc0 + 1) & 255);
    end else begin
      chk("R6 controls", int'({f_stall, d_stall, d_bubble, e_bubble}), 0);
      tick();
      chk("R6 e tag", int'(e_dst), 4);
      chk("R6 d tag", int'(d_dst), 5);
    end
    flush();
  endtask

  task automatic t_ret;
    int pc0;
    int cnt = 0;
    present(RET, NR, NR, NR); tick();
    present(ALU, NR, NR, 7); settle();
    pc0 = int'(pc_q);
    for (int k = 0; k < 8; k++) begin
      if (!f_stall) break;
      chk("R7 d_bubble while ret", int'(d_bubble), 1);
      cnt++;
      tick(); settle();
    end
    chk("R7 stall cycles", cnt, 3);
    chk("R7 pc held", int'(pc_q), pc0);
    chk("R7 ret in W", int'(w_op), RET);
    tick();
    chk("R7 resume tag", int'(d_dst), 7);
    chk("R7 resume op", int'(d_op), ALU);
    flush();
  endtask

  task automatic t_combo_b;
    present(LOAD, NR, NR, 4); tick();
    present(RET, 4, NR, NR); tick(); settle();
    chk("R8 d_stall", int'(d_stall), 1);
    chk("R8 d_bubble", int'(d_bubble), 0);
    chk("R8 f_stall", int'(f_stall), 1);
    chk("R8 e_bubble", int'(e_bubble), 1);
    present(ALU, NR, NR, 9);
    tick(); settle();
    chk("R8 ret held in D", int'(d_op), RET);
    chk("R8 e idle", int'(e_op), NOP);
    chk("R8 now bubbling", int'(d_bubble), 1);
    chk("R8 stall released", int'(d_stall), 0);
    tick();
    chk("R8 ret in E", int'(e_op), RET);
    chk("R8 d idle", int'(d_op), NOP);
    flush();
  endtask

  task automatic t_combo_a;
    present(JCC, NR, NR, NR); tick();
    present(RET, NR, NR, NR); tick();
    exe_cond = 1'b0;
    present(ALU, NR, NR, 8); settle();
    chk("R9 d_bubble", int'(d_bubble), 1);
    chk("R9 e_bubble", int'(e_bubble), 1);
    chk("R9 f_stall", int'(f_stall), 1);
    chk("R9 d_stall", int'(d_stall), 0);
    tick();
    exe_cond = 1'b1; settle();
    chk("R9 d idle", int'(d_op), NOP);
    chk("R9 e idle", int'(e_op), NOP);
    chk("R9 m jump", int'(m_op), JCC);
    chk("R9 no ret left", int'(f_stall), 0);
    flush();
  endtask

  initial begin
    t_reset();
    flush();
    t_load_use(LOAD, 3, 1'b1);
    t_load_use(POP, 2, 1'b0);
    t_noreg();
    t_jump(1'b0);
    t_jump(1'b1);
    t_ret();
    t_combo_b();
    t_combo_a();
    chk("R11 conflict flag", int'(conflict_err), 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule